// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block collects the event sources of a USB host controller into a sticky status register and drives a single interrupt request toward the host bus. An enable register selects which status bits may raise the request, and a master enable sits on top of all of them. The events arrive in several forms. Start of frame, scheduling overrun and system error come in as pulses or levels. The frame number, the bus resume indication and the root hub status words come in as raw values, and the block itself finds the transitions in them that count as events.

Software talks to the block through a small command port. Each command is an 8-bit code, and bit 7 of the code marks a write. Status bits are cleared by writing 1 to them. Enable bits are set by one command code and cleared by another, and in both cases only the bits written as 1 change. A 2-bit counter tallies scheduling overruns and can be read back. Read data is registered.

Top module: `hc_irq_aggr`

## Requirements
- R1: After reset the status register, the enable register (including the master enable) and the overrun count all read 0, and `irq_o` is low.
- R2: `irq_o` is a registered level. It is 1 exactly when some status bit and its matching enable bit are both 1 and the master enable (enable bit 31) is 1. It changes on the same clock edge as the register update that makes the condition true or false.
- R3: Code 0x84 sets every enable bit that is written as 1 and leaves the bits written as 0 unchanged. Code 0x04 reads the enable register. Only bits 0, 2, 3, 4, 5, 6 and 31 are implemented, and every other enable bit reads 0.
- R4: Code 0x85 clears every enable bit that is written as 1, and bits written as 0 keep their value. No other command clears an enable bit.
- R5: Code 0x03 reads the status register. Code 0x83 clears every status bit written as 1, and bits written as 0 keep their value. Bits 1 and 7..31 always read 0.
- R6: Status bit 5 is set on every clock in which bit 15 of `frm_num_i` differs from its value in the previous cycle, whether it rises or falls. A change in any lower frame-number bit does not set it.
- R7: Status bit 3 is set when `bus_resume_i` goes from 0 to 1 while `sw_resume_i` is 0. Holding `bus_resume_i` high does not set it again, and a rise while `sw_resume_i` is 1 does not set it.
- R8: A cycle with `sof_i` high sets status bit 2. A cycle with `sys_err_i` high sets status bit 4.
- R9: Each cycle with `sched_ovr_i` high sets status bit 0 and increments a 2-bit overrun count, which wraps from 3 to 0. Code 0x02 reads the count in bits 1:0.
- R10: Status bit 6 is set when the hub status word or either of the two port status words differs from its value in the previous cycle.
- R11: When an event and a clear write of the same status bit fall in the same cycle, the bit ends up set.
- R12: Read data appears on `rd_data_o` on the clock edge that accepts the read command and holds until the next read. Write commands and unknown codes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 8 | Command code; bit 7 set means write |
| wr_data_i | input | 32 | Write data (bit mask for set/clear commands) |
| rd_data_o | output | 32 | Registered read data |
| sof_i | input | 1 | Start-of-frame event pulse |
| sched_ovr_i | input | 1 | Scheduling overrun event pulse |
| sys_err_i | input | 1 | Unrecoverable system error flag |
| bus_resume_i | input | 1 | Resume signaling present on the bus |
| sw_resume_i | input | 1 | Controller placed in resume state by software |
| frm_num_i | input | 16 | Current frame number |
| hub_stat_i | input | 32 | Root hub status word |
| port_stat_i | input | 64 | Two port status words, port 0 in bits 31:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench moves the frame number both across bit 15 and only in its lower bits. A detector that looks only for rising edges, or that compares the whole word, would miss the falling crossing or set the bit on ordinary frame counting. It holds bus resume high over several cycles and raises it while the software resume flag is set, which catches a level-sensitive detector or one that ignores the software flag. Write-one masks are checked with zero and all-ones data on every register, so a write that stores the data instead of merging it wipes the other bits, and an all-ones write must not show up in reserved bits. The bench also drives five overruns back to back and lands a clear in the same cycle as a start of frame, to expose a count that saturates or misses pulses and a clear that wins over a new event.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int REG_W  = 32;
  localparam int EV_W   = 7;
  localparam int CNT_W  = 2;

  localparam int B_SO   = 0;
  localparam int B_SF   = 2;
  localparam int B_RD   = 3;
  localparam int B_UE   = 4;
  localparam int B_FNO  = 5;
  localparam int B_RHSC = 6;
  localparam int B_MIE  = 31;

  localparam logic [EV_W-1:0]  EV_MASK = 7'b111_1101;
  localparam logic [REG_W-1:0] EN_MASK = (32'd1 << B_MIE) | {{(REG_W-EV_W){1'b0}}, EV_MASK};

  localparam logic [7:0] CMD_RD_CNT   = 8'h02;
  localparam logic [7:0] CMD_RD_STAT  = 8'h03;
  localparam logic [7:0] CMD_RD_EN    = 8'h04;
  localparam logic [7:0] CMD_CLR_STAT = 8'h83;
  localparam logic [7:0] CMD_SET_EN   = 8'h84;
  localparam logic [7:0] CMD_CLR_EN   = 8'h85;

  function automatic logic is_write(input logic [7:0] code);
    return code[7];
  endfunction

  function automatic logic [REG_W-1:0] w1s(input logic [REG_W-1:0] cur,
                                           input logic [REG_W-1:0] msk);
    return cur | msk;
  endfunction

  function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] cur,
                                           input logic [REG_W-1:0] msk);
    return cur & ~msk;
  endfunction

  function automatic logic irq_want(input logic [EV_W-1:0]  stat,
                                    input logic [REG_W-1:0] en);
    return (|(stat & en[EV_W-1:0])) & en[B_MIE];
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cnt,
                                                input logic inc);
    return inc ? cnt + {{(CNT_W-1){1'b0}}, 1'b1} : cnt;
  endfunction
endpackage

// File: rtl/hc_irq_evt_detect.sv
module hc_irq_evt_detect
  import hc_irq_pkg::*;
#(
  parameter int FRM_W  = 16,
  parameter int STAT_W = 32,
  parameter int NPORTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof_i,
  input  logic                     sched_ovr_i,
  input  logic                     sys_err_i,
  input  logic                     bus_resume_i,
  input  logic                     sw_resume_i,
  input  logic [FRM_W-1:0]         frm_num_i,
  input  logic [STAT_W-1:0]        hub_stat_i,
  input  logic [NPORTS*STAT_W-1:0] port_stat_i,
  output logic [EV_W-1:0]          evt_o
);
  localparam int FRM_MSB = FRM_W - 1;

  logic                primed_q;
  logic                frm_msb_q;
  logic                resume_q;
  logic [STAT_W-1:0]   hub_q;
  logic [NPORTS-1:0]   port_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      frm_msb_q <= 1'b0;
      resume_q  <= 1'b0;
      hub_q     <= '0;
    end else begin
      primed_q  <= 1'b1;
      frm_msb_q <= frm_num_i[FRM_MSB];
      resume_q  <= bus_resume_i;
      hub_q     <= hub_stat_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [STAT_W-1:0] prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= port_stat_i[p*STAT_W +: STAT_W];
    end
    assign port_chg[p] = (prev_q != port_stat_i[p*STAT_W +: STAT_W]);
  end

  logic frm_flip, resume_rise, hub_chg;
  assign frm_flip    = primed_q && (frm_num_i[FRM_MSB] != frm_msb_q);
  assign resume_rise = primed_q && bus_resume_i && !resume_q && !sw_resume_i;
  assign hub_chg     = primed_q && ((hub_q != hub_stat_i) || (|port_chg));

  always_comb begin
    evt_o         = '0;
    evt_o[B_SO]   = sched_ovr_i;
    evt_o[B_SF]   = sof_i;
    evt_o[B_RD]   = resume_rise;
    evt_o[B_UE]   = sys_err_i;
    evt_o[B_FNO]  = frm_flip;
    evt_o[B_RHSC] = hub_chg;
  end
endmodule

// File: rtl/hc_irq_status_reg.sv
module hc_irq_status_reg
  import hc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  evt_i,
  input  logic             clr_i,
  input  logic [EV_W-1:0]  clr_mask_i,
  output logic [EV_W-1:0]  stat_d_o,
  output logic [EV_W-1:0]  stat_q_o,
  output logic [CNT_W-1:0] cnt_q_o
);
  logic [EV_W-1:0]  stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EV_W-1:0]  kept;

  always_comb begin
    kept     = clr_i ? (stat_q & ~clr_mask_i) : stat_q;
    stat_d_o = (kept | evt_i) & EV_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      cnt_q  <= '0;
    end else begin
      stat_q <= stat_d_o;
      cnt_q  <= cnt_step(cnt_q, evt_i[B_SO]);
    end
  end

  assign stat_q_o = stat_q;
  assign cnt_q_o  = cnt_q;
endmodule

// File: rtl/hc_irq_enable_reg.sv
module hc_irq_enable_reg
  import hc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_d_o,
  output logic [REG_W-1:0] en_q_o
);
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] msk;
  logic [REG_W-1:0] after_set;

  always_comb begin
    msk       = wdata_i & EN_MASK;
    after_set = set_i ? w1s(en_q, msk) : en_q;
    en_d_o    = clr_i ? w1c(after_set, msk) : after_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d_o;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/hc_irq_aggr.sv
module hc_irq_aggr
  import hc_irq_pkg::*;
#(
  parameter int FRM_W  = 16,
  parameter int STAT_W = 32,
  parameter int NPORTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  input  logic [7:0]               cmd_code_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output logic [REG_W-1:0]         rd_data_o,
  input  logic                     sof_i,
  input  logic                     sched_ovr_i,
  input  logic                     sys_err_i,
  input  logic                     bus_resume_i,
  input  logic                     sw_resume_i,
  input  logic [FRM_W-1:0]         frm_num_i,
  input  logic [STAT_W-1:0]        hub_stat_i,
  input  logic [NPORTS*STAT_W-1:0] port_stat_i,
  output logic                     irq_o
);
  logic             do_clr_stat, do_set_en, do_clr_en, do_read;
  logic [EV_W-1:0]  evt_vec;
  logic [EV_W-1:0]  stat_d, stat_q;
  logic [CNT_W-1:0] ovr_cnt;
  logic [REG_W-1:0] en_d, en_q;
  logic [REG_W-1:0] rd_q;
  logic             irq_q;

  assign do_read     = cmd_valid_i && !is_write(cmd_code_i);
  assign do_clr_stat = cmd_valid_i && (cmd_code_i == CMD_CLR_STAT);
  assign do_set_en   = cmd_valid_i && (cmd_code_i == CMD_SET_EN);
  assign do_clr_en   = cmd_valid_i && (cmd_code_i == CMD_CLR_EN);

  hc_irq_evt_detect #(.FRM_W(FRM_W), .STAT_W(STAT_W), .NPORTS(NPORTS)) u_evt (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .sched_ovr_i(sched_ovr_i),
    .sys_err_i(sys_err_i), .bus_resume_i(bus_resume_i), .sw_resume_i(sw_resume_i),
    .frm_num_i(frm_num_i), .hub_stat_i(hub_stat_i), .port_stat_i(port_stat_i),
    .evt_o(evt_vec)
  );

  hc_irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .clr_i(do_clr_stat),
    .clr_mask_i(wr_data_i[EV_W-1:0]), .stat_d_o(stat_d), .stat_q_o(stat_q),
    .cnt_q_o(ovr_cnt)
  );

  hc_irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .set_i(do_set_en), .clr_i(do_clr_en),
    .wdata_i(wr_data_i), .en_d_o(en_d), .en_q_o(en_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      irq_q <= irq_want(stat_d, en_d);
      if (do_read) begin
        case (cmd_code_i)
          CMD_RD_STAT: rd_q <= {{(REG_W-EV_W){1'b0}}, stat_q};
          CMD_RD_EN:   rd_q <= en_q;
          CMD_RD_CNT:  rd_q <= {{(REG_W-CNT_W){1'b0}}, ovr_cnt};
          default:     rd_q <= rd_q;
        endcase
      end
    end
  end

  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/hc_irq_aggr_chk.sv
module hc_irq_aggr_chk
  import hc_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_code_i,
  input logic             sched_ovr_i,
  input logic             irq_o,
  input logic [EV_W-1:0]  stat_q,
  input logic [REG_W-1:0] en_q,
  input logic [CNT_W-1:0] ovr_cnt,
  input logic [EV_W-1:0]  evt_vec
);
  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((|(stat_q & en_q[EV_W-1:0])) && en_q[B_MIE]));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_i && cmd_code_i == CMD_CLR_EN) |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R5
  stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~EV_MASK) == '0);

  // R3
  en_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_MASK) == '0);

  // R9
  ovr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_ovr_i |=> ovr_cnt == $past(ovr_cnt) + 2'd1);

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_ovr_i |=> $stable(ovr_cnt));

  // R11
  evt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));
endmodule

bind hc_irq_aggr hc_irq_aggr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
  .sched_ovr_i(sched_ovr_i), .irq_o(irq_o), .stat_q(stat_q), .en_q(en_q),
  .ovr_cnt(ovr_cnt), .evt_vec(evt_vec)
);

// File: tb/hc_irq_aggr_tb.sv
module hc_irq_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sof = 1'b0, ovr = 1'b0, serr = 1'b0, bres = 1'b0, swres = 1'b0;
  logic [15:0] frm = '0;
  logic [31:0] hub = '0;
  logic [63:0] ports = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hc_irq_aggr u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sof_i(sof), .sched_ovr_i(ovr),
    .sys_err_i(serr), .bus_resume_i(bres), .sw_resume_i(swres), .frm_num_i(frm),
    .hub_stat_i(hub), .port_stat_i(ports), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic issue(input logic [7:0] code, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_code = code; wr_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] v);
    issue(code, 32'h0);
    v = rd_data;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_stat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(8'h03, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_stat("R1 status", 32'h0);
    rd(8'h04, v); check("R1 enable", v, 32'h0);
    rd(8'h02, v); check("R1 count", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    issue(8'h84, 32'h0000_0005);
    rd(8'h04, v); check("R3 set", v, 32'h0000_0005);
    issue(8'h84, 32'h0);
    rd(8'h04, v); check("R3 zero write", v, 32'h0000_0005);
    issue(8'h84, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R3 all ones", v, 32'h8000_007D);
    issue(8'h85, 32'h0);
    rd(8'h04, v); check("R4 zero clear", v, 32'h8000_007D);
    issue(8'h85, 32'h8000_0041);
    rd(8'h04, v); check("R4 partial clear", v, 32'h0000_003C);
    issue(8'h83, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R4 other cmd", v, 32'h0000_003C);
    issue(8'h85, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R4 full clear", v, 32'h0);
  endtask

  task automatic t_sof_err();
    sof = 1'b1; step(); sof = 1'b0;
    expect_stat("R8 sof", 32'h04);
    serr = 1'b1; step(); serr = 1'b0;
    expect_stat("R8 sys err", 32'h14);
    issue(8'h83, 32'h04);
    expect_stat("R5 w1c", 32'h10);
    issue(8'h83, 32'h0);
    expect_stat("R5 zero write", 32'h10);
    issue(8'h83, 32'hFFFF_FFFF);
    expect_stat("R5 all clear", 32'h0);
  endtask

  task automatic t_frame();
    frm = 16'h7FFF; step();
    expect_stat("R6 low bits", 32'h0);
    frm = 16'h8000; step();
    expect_stat("R6 rise", 32'h20);
    issue(8'h83, 32'h20);
    frm = 16'h8001; step();
    expect_stat("R6 no flip", 32'h0);
    frm = 16'h0000; step();
    expect_stat("R6 fall", 32'h20);
    issue(8'h83, 32'hFF);
  endtask

  task automatic t_resume();
    bres = 1'b1; step();
    expect_stat("R7 rise", 32'h08);
    issue(8'h83, 32'h08);
    step(); step();
    expect_stat("R7 held", 32'h0);
    bres = 1'b0; step();
    swres = 1'b1; bres = 1'b1; step();
    expect_stat("R7 sw resume", 32'h0);
    swres = 1'b0; bres = 1'b0; step();
  endtask

  task automatic t_hub();
    hub = 32'h0000_0100; step();
    expect_stat("R10 hub", 32'h40);
    issue(8'h83, 32'h40);
    ports[63:32] = 32'h0000_0001; step();
    expect_stat("R10 port1", 32'h40);
    issue(8'h83, 32'h40);
    ports[31:0] = 32'h0000_0010; step();
    expect_stat("R10 port0", 32'h40);
    issue(8'h83, 32'h40);
    step();
    expect_stat("R10 steady", 32'h0);
  endtask

  task automatic t_ovr();
    logic [31:0] v;
    ovr = 1'b1;
    repeat (5) step();
    ovr = 1'b0;
    expect_stat("R9 status", 32'h01);
    rd(8'h02, v); check("R9 wrap", v, 32'h1);
    issue(8'h83, 32'h01);
  endtask

  task automatic t_irq();
    issue(8'h84, 32'h04);
    sof = 1'b1; step(); sof = 1'b0;
    check("R2 no master", {31'b0, irq}, 32'h0);
    issue(8'h84, 32'h8000_0000);
    check("R2 master on", {31'b0, irq}, 32'h1);
    issue(8'h83, 32'h04);
    check("R2 status cleared", {31'b0, irq}, 32'h0);
    serr = 1'b1; step(); serr = 1'b0;
    check("R2 unenabled bit", {31'b0, irq}, 32'h0);
    sof = 1'b1; step(); sof = 1'b0;
    check("R2 reassert", {31'b0, irq}, 32'h1);
    issue(8'h85, 32'h8000_0000);
    check("R2 master off", {31'b0, irq}, 32'h0);
    issue(8'h83, 32'hFF);
    issue(8'h85, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    sof = 1'b1;
    issue(8'h83, 32'h04);
    sof = 1'b0;
    expect_stat("R11 set wins", 32'h04);
    issue(8'h83, 32'h04);
  endtask

  task automatic t_rd_hold();
    logic [31:0] v;
    issue(8'h84, 32'h0000_0020);
    rd(8'h04, v); check("R12 read", v, 32'h0000_0020);
    issue(8'h83, 32'hFF);
    check("R12 write holds", rd_data, 32'h0000_0020);
    issue(8'h07, 32'h0);
    check("R12 unknown holds", rd_data, 32'h0000_0020);
    issue(8'h85, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_enable();
    t_sof_err();
    t_frame();
    t_resume();
    t_hub();
    t_ovr();
    t_irq();
    t_race();
    t_rd_hold();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule